// File: doc/BRIEF.md
# Two-wire serial memory slave controller

This block is the bus-side front end of a 256-byte byte-addressed memory on a two-wire open-drain serial bus. It oversamples the clock and data lines with a fast system clock, finds start and stop conditions, and shifts in a header byte that carries a fixed four-bit tag, three strap bits and a direction bit. After the header it accepts a word address and data bytes, or it returns stored bytes. It acknowledges each accepted byte by pulling the data line low. The pull-down is an output-enable that the pad logic turns into an open-drain driver.

Reads use a combinational read port into the array. Writes go out one byte at a time to a separate page-write engine, which receives a commit pulse when the master ends the transaction. While that engine reports busy, the slave does not acknowledge any header. A master can therefore poll the slave until the internal write has finished. A word-address counter keeps its value between transactions. Read addressing wraps across the whole array. Write addressing wraps inside the current 8-byte page.

Top module: `twsm_slave`

## Requirements
- R1: A falling data line while the clock is high is a start. It begins header reception from any state. A rising data line while the clock is high is a stop. It returns the slave to idle, and clocked bytes that follow a stop without a new start are not acknowledged.
- R2: The header is 8 bits, most significant bit first. Bits 7..4 must be 1010, bits 3..1 must equal `strap`, and bit 0 selects read (1) or write (0). On a match the slave holds the data line low for the whole ninth clock. Its pull-down changes only while the synchronised clock is low.
- R3: On a header mismatch the slave does not acknowledge. It ignores all further bytes until the next start.
- R4: While `wr_busy` is high the slave acknowledges no header, neither read nor write. Once `wr_busy` is low again, a matching header is acknowledged.
- R5: After a write header, the next byte is acknowledged and loaded into the word-address counter.
- R6: Each later byte of a write is acknowledged and presented once on `wr_valid`, with `wr_addr` set to the counter. The counter's low 3 bits then increment modulo 8 and the upper 5 bits stay, so a ninth byte overwrites the page's first location.
- R7: `wr_commit` pulses once on a stop that follows at least one accepted data byte. A stop after a header or a word address only (a dummy write) produces no commit.
- R8: A read header returns the byte at the counter, most significant bit first, driven after each falling clock edge. The counter then increments by one.
- R9: A random read is a write header and a word address, then a repeated start and a read header. It returns the byte at the loaded address.
- R10: While the master acknowledges, the slave keeps sending successive bytes. Read addresses wrap from 255 to 0.
- R11: When the master does not acknowledge a read byte, the slave releases the line and drives nothing until the next start. Clocks in that interval do not advance the counter.
- R12: After reset the line is released and the counter is 0. A start, nine clocks with the data line high, then a start and a stop, returns the slave to idle from a mid-write state, with the counter unchanged.
- R13: The counter persists between transactions. After a page write, a current-address read returns the location that follows the last written one within that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_drive_low | output | 1 | Pull-down enable for the data line |
| strap | input | 3 | Strap inputs compared with header bits 3..1 |
| rd_addr | output | 8 | Array read address (the word-address counter) |
| rd_data | input | 8 | Array read data for `rd_addr` |
| wr_valid | output | 1 | One-cycle pulse: a data byte accepted for writing |
| wr_addr | output | 8 | Target address of the accepted byte |
| wr_data | output | 8 | Accepted data byte |
| wr_commit | output | 1 | One-cycle pulse: write transaction ended by a stop |
| wr_busy | input | 1 | Page-write engine is running its internal cycle |

## Verification
Two functions meet when a page write commits and a master polls straight away. The header-decode cycle of a poll can coincide with the engine's busy flag dropping, and the acknowledge decision hangs on the value seen in that cycle. The bench models the engine with a fixed busy window, which starts on the commit pulse. It issues headers back to back from the first stop onward. It expects a missing acknowledge for every poll inside the window and an acknowledge on the first poll after it. The polled byte must still come from the counter position left by the page write.

// File: rtl/twsm_pkg.sv
package twsm_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] HDR_TAG = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } st_e;

    typedef enum logic [1:0] {
        RK_HDR,
        RK_WADDR,
        RK_WDATA
    } rk_e;

    typedef struct packed {
        st_e               st;
        rk_e               kind;
        logic [2:0]        cnt;
        logic              full;
        logic [BYTE_W-1:0] sh;
        logic              drv;
        logic              rd;
        logic              pend;
        logic              wv;
        logic              wc;
        logic [BYTE_W-1:0] wa;
        logic [BYTE_W-1:0] wd;
    } regs_t;
endpackage

// File: rtl/twsm_sync.sv
module twsm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic q,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q, chain_d;
    logic              prev_q, prev_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
        prev_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign q    = chain_q[STAGES-1];
    assign rise = chain_q[STAGES-1] & ~prev_q;
    assign fall = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/twsm_wordctr.sv
module twsm_wordctr #(
    parameter int W      = 8,
    parameter int PAGE_W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc_lin,
    input  logic         inc_page,
    output logic [W-1:0] cur
);
    localparam logic [W-1:0]      ONE_W = W'(1);
    localparam logic [PAGE_W-1:0] ONE_P = PAGE_W'(1);

    logic [W-1:0] cur_q, cur_d;

    always_comb begin
        cur_d = cur_q;
        if (load) begin
            cur_d = load_val;
        end else if (inc_lin) begin
            cur_d = cur_q + ONE_W;
        end else if (inc_page) begin
            cur_d = {cur_q[W-1:PAGE_W], cur_q[PAGE_W-1:0] + ONE_P};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign cur = cur_q;
endmodule

// File: rtl/twsm_slave.sv
module twsm_slave
    import twsm_pkg::*;
#(
    parameter int SYNC_N  = 2,
    parameter int PAGE_W  = 3,
    parameter int STRAP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive_low,
    input  logic [STRAP_W-1:0] strap,
    output logic [BYTE_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_commit,
    input  logic              wr_busy
);
    localparam logic [2:0] LAST_BIT = 3'd7;

    logic scl_q, scl_rise, scl_fall;
    logic sda_q, sda_rise, sda_fall;

    twsm_sync #(.STAGES(SYNC_N)) u_scl (
        .clk(clk), .rst_n(rst_n), .din(scl_in),
        .q(scl_q), .rise(scl_rise), .fall(scl_fall)
    );

    twsm_sync #(.STAGES(SYNC_N)) u_sda (
        .clk(clk), .rst_n(rst_n), .din(sda_in),
        .q(sda_q), .rise(sda_rise), .fall(sda_fall)
    );

    logic start_evt, stop_evt, bus_evt, is_idle, hdr_ok;
    assign start_evt = scl_q & ~scl_rise & sda_fall;
    assign stop_evt  = scl_q & ~scl_rise & sda_rise;
    assign bus_evt   = start_evt | stop_evt;

    regs_t r_q, r_d;

    logic              ctr_load, ctr_inc_lin, ctr_inc_page;
    logic [BYTE_W-1:0] ctr_val, ctr_cur;

    twsm_wordctr #(.W(BYTE_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .load(ctr_load), .load_val(ctr_val),
        .inc_lin(ctr_inc_lin), .inc_page(ctr_inc_page),
        .cur(ctr_cur)
    );

    assign hdr_ok = (r_q.sh[7:4] == HDR_TAG) && (r_q.sh[3:1] == strap) && !wr_busy;

    always_comb begin
        r_d          = r_q;
        r_d.wv       = 1'b0;
        r_d.wc       = 1'b0;
        ctr_load     = 1'b0;
        ctr_val      = r_q.sh;
        ctr_inc_lin  = 1'b0;
        ctr_inc_page = 1'b0;

        if (start_evt) begin
            r_d.st   = ST_RX;
            r_d.kind = RK_HDR;
            r_d.cnt  = '0;
            r_d.full = 1'b0;
            r_d.drv  = 1'b0;
            r_d.pend = 1'b0;
        end else if (stop_evt) begin
            r_d.wc   = r_q.pend;
            r_d.pend = 1'b0;
            r_d.st   = ST_IDLE;
            r_d.drv  = 1'b0;
        end else begin
            case (r_q.st)
                ST_RX: begin
                    if (scl_rise && !r_q.full) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_q};
                        r_d.cnt = r_q.cnt + 3'd1;
                        if (r_q.cnt == LAST_BIT) r_d.full = 1'b1;
                    end else if (scl_fall && r_q.full) begin
                        r_d.full = 1'b0;
                        r_d.cnt  = '0;
                        case (r_q.kind)
                            RK_HDR: begin
                                if (hdr_ok) begin
                                    r_d.st  = ST_ACK;
                                    r_d.drv = 1'b1;
                                    r_d.rd  = r_q.sh[0];
                                end else begin
                                    r_d.st = ST_IDLE;
                                end
                            end
                            RK_WADDR: begin
                                r_d.st   = ST_ACK;
                                r_d.drv  = 1'b1;
                                ctr_load = 1'b1;
                            end
                            default: begin
                                r_d.st       = ST_ACK;
                                r_d.drv      = 1'b1;
                                r_d.wv       = 1'b1;
                                r_d.wa       = ctr_cur;
                                r_d.wd       = r_q.sh;
                                r_d.pend     = 1'b1;
                                ctr_inc_page = 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (r_q.kind == RK_HDR && r_q.rd) begin
                            r_d.st      = ST_TX;
                            r_d.sh      = rd_data;
                            r_d.drv     = ~rd_data[BYTE_W-1];
                            r_d.cnt     = '0;
                            ctr_inc_lin = 1'b1;
                        end else begin
                            r_d.st   = ST_RX;
                            r_d.drv  = 1'b0;
                            r_d.cnt  = '0;
                            r_d.kind = (r_q.kind == RK_HDR) ? RK_WADDR : RK_WDATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.st  = ST_MACK;
                            r_d.drv = 1'b0;
                        end else begin
                            r_d.sh  = {r_q.sh[BYTE_W-2:0], 1'b0};
                            r_d.drv = ~r_q.sh[BYTE_W-2];
                            r_d.cnt = r_q.cnt + 3'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        r_d.full = ~sda_q;
                        if (sda_q) r_d.st = ST_IDLE;
                    end else if (scl_fall && r_q.full) begin
                        r_d.full    = 1'b0;
                        r_d.st      = ST_TX;
                        r_d.sh      = rd_data;
                        r_d.drv     = ~rd_data[BYTE_W-1];
                        r_d.cnt     = '0;
                        ctr_inc_lin = 1'b1;
                    end
                end
                default: begin
                    r_d.drv = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.kind <= RK_HDR;
            r_q.cnt  <= '0;
            r_q.full <= 1'b0;
            r_q.sh   <= '0;
            r_q.drv  <= 1'b0;
            r_q.rd   <= 1'b0;
            r_q.pend <= 1'b0;
            r_q.wv   <= 1'b0;
            r_q.wc   <= 1'b0;
            r_q.wa   <= '0;
            r_q.wd   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign is_idle       = (r_q.st == ST_IDLE);
    assign sda_drive_low = r_q.drv;
    assign rd_addr       = ctr_cur;
    assign wr_valid      = r_q.wv;
    assign wr_addr       = r_q.wa;
    assign wr_data       = r_q.wd;
    assign wr_commit     = r_q.wc;
endmodule

// File: rtl/twsm_slave_chk.sv
module twsm_slave_chk #(
    parameter int W      = 8,
    parameter int PAGE_W = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         scl_s,
    input logic         bus_evt,
    input logic         start,
    input logic         drv,
    input logic         idle,
    input logic         wv,
    input logic         wc,
    input logic [W-1:0] wa
);
    localparam logic [PAGE_W-1:0] ONE_P = PAGE_W'(1);

    logic         seen_q;
    logic [W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (start) begin
            seen_q <= 1'b0;
        end else if (wv) begin
            seen_q <= 1'b1;
            last_q <= wa;
        end
    end

    // R2: the pull-down moves only while the synchronised clock is low
    assert_drive_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_evt && !$stable(drv)) |-> !scl_s);

    // R6: consecutive write bytes stay in one page and step modulo the page size
    assert_page_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wv && seen_q) |-> (wa[W-1:PAGE_W] == last_q[W-1:PAGE_W]
                            && wa[PAGE_W-1:0] == last_q[PAGE_W-1:0] + ONE_P));

    // R7: a commit never shares a cycle with a byte hand-off
    assert_commit_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wv && wc));

    // R11: an idle slave never pulls the line
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !drv);

    // R1: a start releases the line on the following cycle
    assert_start_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !drv);
endmodule

bind twsm_slave twsm_slave_chk #(.W(twsm_pkg::BYTE_W), .PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_q), .bus_evt(bus_evt),
    .start(start_evt), .drv(sda_drive_low), .idle(is_idle),
    .wv(wr_valid), .wc(wr_commit), .wa(wr_addr)
);

// File: tb/twsm_slave_test.sv
module twsm_slave_test;
    localparam int BUSY_CYC = 300;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       msda = 1'b1;
    logic [2:0] strap = 3'd5;
    logic       drv, wv, wc, busy;
    logic [7:0] rd_addr, rd_data, wa, wd;
    logic       sda_bus;
    logic [7:0] mem [256];
    logic [7:0] expm [256];
    int         busy_cnt;
    int         commits;
    int         vectors = 0;
    int         fails = 0;
    bit         done = 1'b0;

    assign sda_bus = msda & ~drv;
    assign rd_data = mem[rd_addr];
    assign busy    = (busy_cnt != 0);

    twsm_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
        .sda_drive_low(drv), .strap(strap), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_valid(wv), .wr_addr(wa), .wr_data(wd), .wr_commit(wc), .wr_busy(busy)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    // page-write engine and array model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i);
            busy_cnt <= 0;
            commits  <= 0;
        end else begin
            if (wv) mem[wa] <= wd;
            if (wc) begin
                commits  <= commits + 1;
                busy_cnt <= BUSY_CYC;
            end else if (busy_cnt != 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        tick(3); msda = b; tick(3); scl = 1'b1; tick(6); scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        tick(3); msda = 1'b1; tick(3); scl = 1'b1; tick(3); b = sda_bus; tick(3); scl = 1'b0;
    endtask

    task automatic bus_start();
        tick(3); msda = 1'b1; tick(3); scl = 1'b1; tick(6); msda = 1'b0; tick(6); scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(3); msda = 1'b0; tick(3); scl = 1'b1; tick(6); msda = 1'b1; tick(6);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~mack);
    endtask

    function automatic logic [7:0] hdr(logic [2:0] s, logic rd);
        return {4'b1010, s, rd};
    endfunction

    int         ectr;
    logic       ack, ack2;
    logic [7:0] v;
    int         base_commits;

    initial begin
        for (int i = 0; i < 256; i++) expm[i] = pat(i);
        ectr = 0;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R12 reset state
        chk("R12 reset release", int'(drv), 0);
        chk("R12 reset no write", int'(wv), 0);
        chk("R12 reset counter", int'(rd_addr), 0);

        // R2 R3 R8: sweep of every header byte
        for (int b = 0; b < 256; b++) begin
            logic exp_ack;
            exp_ack = (b[7:4] == 4'b1010) && (b[3:1] == strap);
            bus_start();
            send_byte(8'(b), ack);
            chk("R2/R3 header ack", int'(ack), int'(exp_ack));
            if (ack && b[0]) begin
                recv_byte(1'b0, v);
                chk("R8 current read", int'(v), int'(expm[ectr]));
                ectr = (ectr + 1) % 256;
            end else if (!ack) begin
                send_byte(8'h00, ack2);
                chk("R3 ignored after mismatch", int'(ack2), 0);
            end
            bus_stop();
        end

        // R2 strap sweep
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            bus_start();
            send_byte(hdr(3'(s), 1'b0), ack);
            chk("R2 strap match", int'(ack), 1);
            bus_stop();
            bus_start();
            send_byte(hdr(3'(s) ^ 3'd2, 1'b0), ack);
            chk("R3 strap mismatch", int'(ack), 0);
            bus_stop();
        end
        strap = 3'd5;

        // R1: bytes after a stop without a start are not acknowledged
        bus_start();
        send_byte(hdr(strap, 1'b0), ack);
        bus_stop();
        tick(3); scl = 1'b0;
        send_byte(hdr(strap, 1'b0), ack);
        chk("R1 no start no ack", int'(ack), 0);

        // R5 R6 R7: page write with wrap
        base_commits = commits;
        bus_start();
        send_byte(hdr(strap, 1'b0), ack);
        chk("R5 write header", int'(ack), 1);
        send_byte(8'h3D, ack);
        chk("R5 word address ack", int'(ack), 1);
        for (int k = 0; k < 10; k++) begin
            logic [7:0] a;
            a = {5'(8'h3D >> 3), 3'(3'd5 + 3'(k))};
            send_byte(8'(8'hC0 + k * 3), ack);
            chk("R6 data ack", int'(ack), 1);
            expm[a] = 8'(8'hC0 + k * 3);
        end
        bus_stop();
        tick(2);
        chk("R7 commit on stop", commits, base_commits + 1);
        ectr = 8'h3F;

        // R4: polling while the engine is busy
        bus_start();
        send_byte(hdr(strap, 1'b0), ack);
        chk("R4 busy write header nack", int'(ack), 0);
        bus_stop();
        begin
            int polls;
            polls = 0;
            ack = 1'b0;
            while (!ack && polls < 40) begin
                bus_start();
                send_byte(hdr(strap, 1'b1), ack);
                if (!ack) bus_stop();
                polls++;
            end
            chk("R4 ack after busy", int'(ack), 1);
            chk("R4 polled more than once", int'(polls > 1), 1);
        end
        recv_byte(1'b0, v);
        chk("R13 counter after page write", int'(v), int'(expm[ectr]));
        ectr = 8'h40;
        bus_stop();

        // R9 R10 R7: random read of the written page, sequential
        base_commits = commits;
        bus_start();
        send_byte(hdr(strap, 1'b0), ack);
        send_byte(8'h38, ack);
        bus_start();
        send_byte(hdr(strap, 1'b1), ack);
        chk("R9 read header after restart", int'(ack), 1);
        for (int k = 0; k < 8; k++) begin
            recv_byte(k < 7, v);
            chk("R9/R10 sequential", int'(v), int'(expm[8'h38 + k]));
        end
        bus_stop();
        tick(2);
        chk("R7 no commit on dummy write", commits, base_commits);

        // R10: wrap across the top of the array
        bus_start();
        send_byte(hdr(strap, 1'b0), ack);
        send_byte(8'hFD, ack);
        bus_start();
        send_byte(hdr(strap, 1'b1), ack);
        for (int k = 0; k < 5; k++) begin
            recv_byte(k < 4, v);
            chk("R10 wrap", int'(v), int'(expm[(8'hFD + k) % 256]));
        end
        bus_stop();
        ectr = 2;

        // R11: master not acknowledging
        bus_start();
        send_byte(hdr(strap, 1'b1), ack);
        recv_byte(1'b0, v);
        chk("R11 byte before nack", int'(v), int'(expm[ectr]));
        ectr++;
        recv_byte(1'b0, v);
        chk("R11 silent after nack", int'(v), 8'hFF);
        bus_stop();
        bus_start();
        send_byte(hdr(strap, 1'b1), ack);
        recv_byte(1'b0, v);
        chk("R11 counter not advanced", int'(v), int'(expm[ectr]));
        bus_stop();

        // R12: recovery sequence from a mid-write state
        bus_start();
        send_byte(hdr(strap, 1'b0), ack);
        send_byte(8'h10, ack);
        chk("R12 address loaded", int'(ack), 1);
        bus_start();
        for (int k = 0; k < 9; k++) put_bit(1'b1);
        bus_start();
        bus_stop();
        chk("R12 released after recovery", int'(drv), 0);
        bus_start();
        send_byte(hdr(strap, 1'b1), ack);
        chk("R12 header after recovery", int'(ack), 1);
        recv_byte(1'b0, v);
        chk("R12 counter kept", int'(v), int'(expm[8'h10]));
        bus_stop();

        tick(10);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule